// File: doc/BRIEF.md
# Request/Acknowledge Pairing Monitor

This block sits beside a request/acknowledge handshake and checks its ordering at run time. Every rising edge of the request line opens a new transaction. Exactly one acknowledge cycle must follow before the next rising edge. The monitor raises a one-cycle error pulse whenever the ordering breaks. It also sets a sticky flag and records a code for the cause. A mode input can require at least one quiet acknowledge cycle between the acknowledge and the next request.

The monitor has no timeout. A transaction may stay open for any number of cycles.

The core is a four-state machine:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | No request is pending. This is the state after reset. |
| `ST_WAIT_ACK` | A request is open and no acknowledge has been counted yet. |
| `ST_ACK_FRESH` | One acknowledge has been counted, and the acknowledge line was high in the previous cycle. |
| `ST_ACK_QUIET` | One acknowledge has been counted, and at least one low acknowledge cycle has followed it. |

The transitions are:

- **open**: any state goes to `ST_WAIT_ACK` on a request edge.
- **take**: `ST_WAIT_ACK` goes to `ST_ACK_FRESH` when the acknowledge is high and there is no edge.
- **settle**: `ST_ACK_FRESH` goes to `ST_ACK_QUIET` when both the acknowledge and the edge are low.
- **repeat**: `ST_ACK_QUIET` goes to `ST_ACK_FRESH` on a second acknowledge, which is an error.
- **stray**: `ST_IDLE` stays in `ST_IDLE` on an acknowledge with no request, which is an error.

All other cases hold the current state.

Top module: `req_ack_pair_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), all outputs are cleared after that edge. `err_cause_o` becomes 2'b00 and the monitor returns to idle with no request pending.
- R2: A new request is recognised only when `req_i` is sampled high after being sampled low in the previous cycle. Holding `req_i` high creates no further requests.
- R3: An acknowledge in the same cycle as a request edge does not count toward that request.
- R4: A request edge while the open request has no counted acknowledge is a missing-acknowledge error. The cause code is 2'b01.
- R5: A second acknowledge cycle for the same request, before the next request edge, is an extra-acknowledge error. The cause code is 2'b10.
- R6: With `gap_mode_i` low, a request edge in the cycle right after the acknowledge is legal.
- R7: With `gap_mode_i` high, a request edge in the cycle right after the acknowledge is a gap error with cause code 2'b11. A request edge after at least one low acknowledge cycle is legal.
- R8: An acknowledge while no request is pending is an unsolicited error. The cause code is 2'b11.
- R9: Any number of cycles may pass between a request, its acknowledge and the next request without an error. A cycle with neither a request edge nor an acknowledge never produces an error.
- R10: `err_pulse_o` is high for exactly the cycle after each offending input cycle. `err_cause_o` shows the cause of the most recent error and holds that value.
- R11: `err_sticky_o` is set by the first error and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request line; its rising edge opens a transaction |
| ack_i | input | 1 | Acknowledge line |
| gap_mode_i | input | 1 | 1 = a low acknowledge cycle is required before the next request |
| err_pulse_o | output | 1 | One-cycle error strobe |
| err_sticky_o | output | 1 | Set by any error; cleared only by reset |
| err_cause_o | output | 2 | Cause of the latest error: 01 missing, 10 extra, 11 gap or unsolicited |

## Verification
The bench holds the request line high across an acknowledge. A level-sensitive design would then report a missing acknowledge on a request that does not exist. The bench drives an acknowledge together with a request edge and then a second edge. A design that counted that acknowledge would stay silent instead of flagging the missing acknowledge.

The same back-to-back acknowledge-then-request sequence is run in both modes. A design that swapped the gap rule, or applied it one cycle late, would flag the default mode or pass the gap mode. A long silent wait checks that no hidden timeout exists. A stray acknowledge straight after reset checks the idle state. Resets before and after errors show whether the sticky flag and the cause code clear.

// File: rtl/rapc_pkg.sv
package rapc_pkg;

    // Position of the transaction for the request that is open now
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_ACK  = 2'd1,
        ST_ACK_FRESH = 2'd2,
        ST_ACK_QUIET = 2'd3
    } rapc_state_e;

    localparam int CAUSE_W = 2;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_MISSING = 2'b01,
        CAUSE_EXTRA   = 2'b10,
        CAUSE_ORDER   = 2'b11
    } rapc_cause_e;

endpackage

// File: rtl/rapc_edge_detect.sv
module rapc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_i;
        end
    end

    // A request is new only when the line was sampled low one cycle earlier
    assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/rapc_seq_fsm.sv
module rapc_seq_fsm
    import rapc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_edge_i,
    input  logic        ack_i,
    input  logic        gap_mode_i,
    output rapc_state_e state_o,
    output logic        err_evt_o,
    output rapc_cause_e err_code_o
);

    rapc_state_e state_q;
    rapc_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and error decision
    always_comb begin
        state_d    = state_q;
        err_evt_o  = 1'b0;
        err_code_o = CAUSE_NONE;

        unique case (state_q)
            ST_IDLE: begin
                if (req_edge_i) begin
                    // open: any acknowledge in this cycle is not counted
                    state_d = ST_WAIT_ACK;
                end else if (ack_i) begin
                    // stray acknowledge with nothing pending
                    err_evt_o  = 1'b1;
                    err_code_o = CAUSE_ORDER;
                end
            end

            ST_WAIT_ACK: begin
                if (req_edge_i) begin
                    err_evt_o  = 1'b1;
                    err_code_o = CAUSE_MISSING;
                    state_d    = ST_WAIT_ACK;
                end else if (ack_i) begin
                    state_d = ST_ACK_FRESH;
                end
            end

            ST_ACK_FRESH: begin
                if (req_edge_i) begin
                    if (gap_mode_i) begin
                        err_evt_o  = 1'b1;
                        err_code_o = CAUSE_ORDER;
                    end
                    state_d = ST_WAIT_ACK;
                end else if (ack_i) begin
                    err_evt_o  = 1'b1;
                    err_code_o = CAUSE_EXTRA;
                end else begin
                    state_d = ST_ACK_QUIET;
                end
            end

            ST_ACK_QUIET: begin
                if (req_edge_i) begin
                    state_d = ST_WAIT_ACK;
                end else if (ack_i) begin
                    err_evt_o  = 1'b1;
                    err_code_o = CAUSE_EXTRA;
                    state_d    = ST_ACK_FRESH;
                end
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/rapc_err_reg.sv
module rapc_err_reg
    import rapc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_i,
    input  rapc_cause_e        code_i,
    output logic               pulse_o,
    output logic               sticky_o,
    output logic [CAUSE_W-1:0] cause_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o  <= 1'b0;
            sticky_o <= 1'b0;
            cause_o  <= CAUSE_NONE;
        end else begin
            pulse_o <= evt_i;
            if (evt_i) begin
                sticky_o <= 1'b1;
                cause_o  <= code_i;
            end
        end
    end

endmodule

// File: rtl/req_ack_pair_checker.sv
module req_ack_pair_checker
    import rapc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               ack_i,
    input  logic               gap_mode_i,
    output logic               err_pulse_o,
    output logic               err_sticky_o,
    output logic [CAUSE_W-1:0] err_cause_o
);

    logic        req_edge;
    logic        err_evt;
    rapc_cause_e err_code;
    rapc_state_e fsm_state;

    rapc_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (req_i),
        .rise_o  (req_edge)
    );

    rapc_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_edge_i (req_edge),
        .ack_i      (ack_i),
        .gap_mode_i (gap_mode_i),
        .state_o    (fsm_state),
        .err_evt_o  (err_evt),
        .err_code_o (err_code)
    );

    rapc_err_reg u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (err_evt),
        .code_i   (err_code),
        .pulse_o  (err_pulse_o),
        .sticky_o (err_sticky_o),
        .cause_o  (err_cause_o)
    );

    // Each request edge leaves a request pending (R2)
    p_edge_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_edge |=> (fsm_state == ST_WAIT_ACK));

    // Missing acknowledge is reported one cycle later (R4)
    p_missing_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_WAIT_ACK && req_edge)
        |=> (err_pulse_o && err_cause_o == 2'b01));

    // Second acknowledge for one request (R5)
    p_extra_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_state == ST_ACK_FRESH || fsm_state == ST_ACK_QUIET) && ack_i && !req_edge)
        |=> (err_pulse_o && err_cause_o == 2'b10));

    // Gap rule violation (R7)
    p_gap_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_mode_i && fsm_state == ST_ACK_FRESH && req_edge)
        |=> (err_pulse_o && err_cause_o == 2'b11));

    // Acknowledge with no request pending (R8)
    p_stray_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && ack_i && !req_edge)
        |=> (err_pulse_o && err_cause_o == 2'b11));

    // Quiet input cycles never raise an error (R9)
    p_quiet_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_edge && !ack_i) |=> !err_pulse_o);

    // A pulse always comes with the sticky flag and a nonzero cause (R10)
    p_pulse_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> (err_sticky_o && err_cause_o != 2'b00));

    // The sticky flag holds until reset (R11)
    p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky_o |=> err_sticky_o);

endmodule

// File: tb/req_ack_pair_checker_tb_top.sv
module req_ack_pair_checker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       gap_mode_i = 1'b0;
    logic       err_pulse_o;
    logic       err_sticky_o;
    logic [1:0] err_cause_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    req_ack_pair_checker dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .ack_i        (ack_i),
        .gap_mode_i   (gap_mode_i),
        .err_pulse_o  (err_pulse_o),
        .err_sticky_o (err_sticky_o),
        .err_cause_o  (err_cause_o)
    );

    // Vector fields: [9:6] requirement number, [5] gap, [4] req, [3] ack,
    // [2] expected pulse, [1:0] expected cause after that cycle
    localparam int NV = 23;
    localparam logic [9:0] VEC [NV] = '{
        {4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 2'b00}, // R9 idle
        {4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 2'b00}, // R2 edge opens
        {4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 2'b00}, // R2 held high, no new request
        {4'd2,  1'b0, 1'b1, 1'b1, 1'b0, 2'b00}, // R2 ack while held
        {4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 2'b00}, // R2 still high, no error
        {4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 2'b00}, // R9
        {4'd6,  1'b0, 1'b1, 1'b0, 1'b0, 2'b00}, // R6 new edge
        {4'd6,  1'b0, 1'b0, 1'b1, 1'b0, 2'b00}, // R6 ack
        {4'd6,  1'b0, 1'b1, 1'b0, 1'b0, 2'b00}, // R6 edge right after ack is legal
        {4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 2'b00}, // R9
        {4'd4,  1'b0, 1'b1, 1'b0, 1'b1, 2'b01}, // R4 missing ack
        {4'd10, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01}, // R10 pulse one cycle, cause held
        {4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 2'b01}, // R9
        {4'd5,  1'b0, 1'b0, 1'b1, 1'b1, 2'b10}, // R5 extra ack after quiet
        {4'd5,  1'b0, 1'b0, 1'b1, 1'b1, 2'b10}, // R5 extra ack back to back
        {4'd3,  1'b0, 1'b1, 1'b1, 1'b0, 2'b10}, // R3 edge with ack
        {4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 2'b10}, // R9
        {4'd3,  1'b0, 1'b1, 1'b0, 1'b1, 2'b01}, // R3 same-cycle ack was not counted
        {4'd7,  1'b1, 1'b0, 1'b1, 1'b0, 2'b01}, // R7 ack in gap mode
        {4'd7,  1'b1, 1'b1, 1'b0, 1'b1, 2'b11}, // R7 edge right after ack
        {4'd7,  1'b1, 1'b0, 1'b1, 1'b0, 2'b11}, // R7 ack
        {4'd7,  1'b1, 1'b0, 1'b0, 1'b0, 2'b11}, // R7 quiet gap cycle
        {4'd7,  1'b1, 1'b1, 1'b0, 1'b0, 2'b11}  // R7 edge after gap is legal
    };

    task automatic chk(input int rq, input logic [3:0] act, input logic [3:0] exp,
                       input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic cyc(input logic g, input logic r, input logic a);
        @(negedge clk);
        gap_mode_i = g;
        req_i      = r;
        ack_i      = a;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_i = 1'b0;
        ack_i = 1'b0;
        gap_mode_i = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit quiet_ok;

        do_reset();
        // R1 reset state
        chk(1, {3'b0, err_pulse_o}, 4'd0, "pulse after reset");
        chk(1, {3'b0, err_sticky_o}, 4'd0, "sticky after reset");
        chk(1, {2'b0, err_cause_o}, 4'd0, "cause after reset");

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][5], VEC[i][4], VEC[i][3]);
            chk(int'(VEC[i][9:6]), {3'b0, err_pulse_o}, {3'b0, VEC[i][2]}, "pulse");
            chk(int'(VEC[i][9:6]), {2'b0, err_cause_o}, {2'b0, VEC[i][1:0]}, "cause");
        end

        // R11 sticky stays set through clean cycles
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk(11, {3'b0, err_sticky_o}, 4'd1, "sticky held");

        // R1 reset clears everything, including a pending request
        do_reset();
        chk(1, {3'b0, err_sticky_o}, 4'd0, "sticky cleared");
        chk(1, {2'b0, err_cause_o}, 4'd0, "cause cleared");

        // R8 ack straight after reset has no request to serve
        cyc(1'b0, 1'b0, 1'b1);
        chk(8, {3'b0, err_pulse_o}, 4'd1, "stray ack pulse");
        chk(8, {2'b0, err_cause_o}, 4'd3, "stray ack cause");
        cyc(1'b0, 1'b0, 1'b0);
        chk(10, {3'b0, err_pulse_o}, 4'd0, "pulse dropped");

        // R9 long waits without timeout
        do_reset();
        cyc(1'b0, 1'b1, 1'b0);
        quiet_ok = 1'b1;
        for (int k = 0; k < 2000; k++) begin
            cyc(1'b0, 1'b0, 1'b0);
            if (err_pulse_o !== 1'b0) quiet_ok = 1'b0;
        end
        cyc(1'b0, 1'b0, 1'b1);
        if (err_pulse_o !== 1'b0) quiet_ok = 1'b0;
        for (int k = 0; k < 500; k++) begin
            cyc(1'b0, 1'b0, 1'b0);
            if (err_pulse_o !== 1'b0) quiet_ok = 1'b0;
        end
        cyc(1'b0, 1'b1, 1'b0);
        if (err_pulse_o !== 1'b0) quiet_ok = 1'b0;
        chk(9, {3'b0, quiet_ok}, 4'd1, "no error over long waits");
        chk(9, {3'b0, err_sticky_o}, 4'd0, "sticky clean after long waits");

        // R4 the long-open request with no ack is still caught
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        chk(4, {3'b0, err_pulse_o}, 4'd1, "missing ack pulse");
        chk(4, {2'b0, err_cause_o}, 4'd1, "missing ack cause");

        finish_run();
    end

endmodule